// File: doc/BRIEF.md
# Thermometer-Domain Digital Loop Filter

This block is the smoothing stage of an all-digital clock multiplier. On every edge of the reference sample clock it receives one word from a tapped delay-line phase sampler. The word is a thermometer code, and the number of ones in it grows with the measured phase difference. The block turns that word into a small binary count and keeps the last four counts. It averages them and expands the average back into a thermometer word. Each bit of that word steers one stage of a digitally controlled ring oscillator.

The input word passes through a register before it is encoded. The average is also registered before it reaches the oscillator. A sample therefore takes several reference cycles to reach the output, and a sampled bit that is still settling has that time to resolve. The encoder counts the ones in the word instead of searching for the first zero, so a word with a bubble still yields a count that grows with the phase difference. The arithmetic runs on narrow binary values, and only the ends of the path are one bit per stage.

Top module: `therm_loop_filter`

## Requirements
- R1: A word presented on `tdc_therm` is captured at one rising edge of `clk`. It first affects `dco_therm` after the second rising edge that follows that capture.
- R2: A captured word is encoded as the number of ones it holds, whatever their positions. A word with bubbles, such as `16'h00D7`, counts the same as a clean run of six ones.
- R3: A word with all 16 bits set encodes to 15, so every encoded value fits in 4 bits.
- R4: The filtered value is the sum of the four most recent encoded samples shifted right by two, which truncates the mean. Taps not yet filled since reset count as zero.
- R5: `dco_therm` is a thermometer word. Bit i is 1 exactly when i is less than the filtered value, so bit 15 is never set.
- R6: While `rst_n` is low at a rising edge, that edge clears the input register, all four taps and `dco_therm` to zero. Reset is synchronous and active low.
- R7: After four identical captured words whose count is k (k at most 15), `dco_therm` settles to exactly k ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdc_therm | input | 16 | Thermometer-coded phase sample from the delay line |
| dco_therm | output | 16 | Thermometer control word, one bit per oscillator stage |

## Verification
The bench checks each output word against a queue-based model of the four-sample mean. It drives steps, a full ramp from zero to sixteen ones, bubbled words, a lone full-scale pulse, and a reset in the middle of the run.

- **Lone full-scale pulse.** A delay that is one cycle off shows the resulting `0x0007` on the wrong cycle.
- **Saturated input.** An encoder without saturation wraps sixteen ones to zero and drives the output to zero.
- **Bubbled words.** A first-zero search reports far fewer ones than the word holds.
- **Averaging.** Rounding instead of truncating, or averaging the wrong number of taps, makes the step and ramp outputs differ by one or more stages.
- **Mid-run reset.** Taps left uncleared by reset let stale phase leak into the output after release.

// File: rtl/therm_loop_filter.sv
module therm_loop_filter #(
  parameter int THERM_W = 16,
  parameter int TAPS    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [THERM_W-1:0] tdc_therm,
  output logic [THERM_W-1:0] dco_therm
);
  localparam int BIN_W   = $clog2(THERM_W);
  localparam int CNT_W   = $clog2(THERM_W + 1);
  localparam int AVG_SH  = $clog2(TAPS);
  localparam int SUM_W   = BIN_W + AVG_SH;
  localparam int BIN_MAX = (1 << BIN_W) - 1;

  logic [THERM_W-1:0]    samp_q;
  logic [CNT_W-1:0]      ones;
  logic [BIN_W-1:0]      code;
  logic [BIN_W-1:0]      tap_q [TAPS];
  logic [TAPS*BIN_W-1:0] taps_flat;
  logic [SUM_W-1:0]      sum;
  logic [BIN_W-1:0]      mean;
  logic [THERM_W-1:0]    therm_next;

  always_ff @(posedge clk) begin
    if (!rst_n) samp_q <= '0;
    else        samp_q <= tdc_therm;
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < THERM_W; i++) ones = ones + CNT_W'(samp_q[i]);
  end

  assign code = (ones > CNT_W'(BIN_MAX)) ? BIN_W'(BIN_MAX) : ones[BIN_W-1:0];

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) tap_q[g] <= '0;
        else        tap_q[g] <= code;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) tap_q[g] <= '0;
        else        tap_q[g] <= tap_q[g-1];
      end
    end
    assign taps_flat[g*BIN_W +: BIN_W] = tap_q[g];
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < TAPS; i++) sum = sum + SUM_W'(tap_q[i]);
  end

  assign mean = sum[SUM_W-1:AVG_SH];

  always_comb begin
    for (int i = 0; i < THERM_W; i++) therm_next[i] = (i < int'(mean));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dco_therm <= '0;
    else        dco_therm <= therm_next;
  end
endmodule

// File: rtl/therm_loop_filter_chk.sv
module therm_loop_filter_chk #(
  parameter int THERM_W = 16,
  parameter int TAPS    = 4,
  parameter int BIN_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [THERM_W-1:0] samp_q,
  input logic [TAPS*BIN_W-1:0] taps_flat,
  input logic [THERM_W-1:0] dco_therm
);
  logic taps_same;
  always_comb begin
    taps_same = 1'b1;
    for (int i = 1; i < TAPS; i++)
      if (taps_flat[i*BIN_W +: BIN_W] != taps_flat[BIN_W-1:0]) taps_same = 1'b0;
  end

  assert_reset_clear_R6: assert property (@(posedge clk)
    !rst_n |=> (dco_therm == '0 && taps_flat == '0));

  assert_therm_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dco_therm + THERM_W'(1)) & dco_therm) == '0);

  assert_top_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dco_therm[THERM_W-1]);

  assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&samp_q) |=> (&taps_flat[BIN_W-1:0]));

  assert_count_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(samp_q) < THERM_W) |=> int'(taps_flat[BIN_W-1:0]) == $countones($past(samp_q)));

  assert_steady_mean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taps_same |=> $countones(dco_therm) == int'($past(taps_flat[BIN_W-1:0])));
endmodule

bind therm_loop_filter therm_loop_filter_chk #(
  .THERM_W(THERM_W), .TAPS(TAPS), .BIN_W(BIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .samp_q(samp_q), .taps_flat(taps_flat), .dco_therm(dco_therm)
);

// File: tb/test_therm_loop_filter.sv
module test_therm_loop_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tdc_therm = 16'hFFFF;
  logic [15:0] dco_therm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int hist[$];

  therm_loop_filter i_therm_loop_filter (
    .clk(clk), .rst_n(rst_n), .tdc_therm(tdc_therm), .dco_therm(dco_therm)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] therm(input int k);
    logic [16:0] t;
    t = (17'd1 << k) - 17'd1;
    return t[15:0];
  endfunction

  function automatic int enc(input logic [15:0] w);
    int c = 0;
    for (int i = 0; i < 16; i++) if (w[i]) c++;
    return (c > 15) ? 15 : c;
  endfunction

  function automatic logic [15:0] model_out();
    int s = 0;
    for (int i = 2; i < 6; i++) s += hist[i];
    return therm(s / 4);
  endfunction

  task automatic check(input logic [15:0] exp, input string req);
    n_cmp++;
    if (dco_therm !== exp) begin
      n_bad++;
      $display("FAIL %s: dco_therm=%h expected=%h", req, dco_therm, exp);
    end
  endtask

  task automatic clear_model();
    hist.delete();
    for (int i = 0; i < 6; i++) hist.push_back(0);
  endtask

  task automatic step(input logic [15:0] v, input string req);
    tdc_therm = v;
    @(posedge clk);
    hist.push_front(enc(v));
    void'(hist.pop_back());
    @(negedge clk);
    check(model_out(), req);
  endtask

  task automatic do_reset(input int cycles);
    rst_n = 1'b0;
    tdc_therm = 16'hFFFF;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(16'h0000, "R6");
    end
    rst_n = 1'b1;
    clear_model();
  endtask

  initial begin
    clear_model();
    do_reset(3);
    step(16'h0000, "R6");
    step(16'h0000, "R6");
    // lone full-scale pulse: zero on first two edges, then 0x0007 (mean 15/4=3)
    step(16'hFFFF, "R1");
    step(16'h0000, "R1");
    step(16'h0000, "R1");
    step(16'h0000, "R1");
    step(16'h0000, "R1");
    step(16'h0000, "R1");
    // step up to 8 ones and hold
    for (int i = 0; i < 7; i++) step(therm(8), "R7");
    // step down to 3 ones
    for (int i = 0; i < 7; i++) step(therm(3), "R4");
    // ramp across full range including saturation
    for (int k = 0; k <= 16; k++) step(therm(k), "R2");
    // saturated hold: output 0x7FFF, top bit clear
    for (int i = 0; i < 6; i++) step(16'hFFFF, "R3");
    check(16'h7FFF, "R5");
    // bubbled words
    for (int i = 0; i < 6; i++) step(16'h00D7, "R2");
    check(therm(6), "R2");
    step(16'h8001, "R2");
    step(16'h5555, "R2");
    step(16'hA0F0, "R4");
    step(16'h0003, "R4");
    for (int i = 0; i < 5; i++) step(16'h0000, "R4");
    // mid-run reset with taps loaded
    for (int i = 0; i < 6; i++) step(therm(12), "R7");
    do_reset(2);
    for (int i = 0; i < 4; i++) step(16'h0000, "R6");
    for (int i = 0; i < 6; i++) step(therm(5), "R7");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule